// File: doc/BRIEF.md
# Word Serializer with Internal Loopback

The block turns a stream of 10-bit parallel words into a serial NRZ bit stream. It runs on a single clock at the bit rate. An internal slot counter splits that clock into word periods of ten bit slots each. On the edge that opens a word period, the block captures the parallel input word. It then sends that word one bit per clock, least significant bit first. The word-period marker is brought out as `wordSync`, so the sender knows which edge takes its word.

A loopback control selects one of two paths:

- **Normal operation (loopback low).** The serial stream drives the external line output. The receive-side serial output passes the external serial input through unchanged.
- **Loopback (loopback high).** The serial stream goes to the receive-side output instead. The external line output is held at a constant 0.

The loopback control is sampled only at word boundaries. A word is therefore never split between the two destinations.

Top module: `ser_loopback_top`

## Requirements
- R1: After reset, and until the first captured word starts, `lineOut` is 0. Because the loopback state is off after reset, `rxSerial` equals `serialIn` in that interval.
- R2: `wordSync` is high for one cycle in every `BITS` (10) cycles. It is high in the first cycle after reset is released.
- R3: At each rising edge where `wordSync` is high, the block captures `txWord`. While loopback is off, bit k of that word appears on `lineOut` in the (k+1)-th cycle after the capture edge, for k = 0..9. Bit 0 is sent first.
- R4: While the loopback state is on, `rxSerial` carries the transmit bit sequence, in the same slots that R3 gives for `lineOut`.
- R5: While the loopback state is on, `lineOut` is held at 0 in every bit slot.
- R6: While the loopback state is off, `rxSerial` equals `serialIn` in the same cycle.
- R7: `loopEn` is sampled only at a capture edge, that is, an edge where `wordSync` is high. The sampled value governs all ten slots of that word. A change of `loopEn` inside a word has no effect until the next capture.
- R8: Changes to `txWord` at edges where `wordSync` is low do not alter the bits of the word being sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bit-rate clock |
| rstN | input | 1 | Asynchronous reset, active low |
| txWord | input | 10 | Parallel word to serialize, captured when `wordSync` is high |
| loopEn | input | 1 | Loopback request, sampled at word boundaries |
| serialIn | input | 1 | External serial receive input |
| lineOut | output | 1 | External serial transmit output |
| rxSerial | output | 1 | Receive-side serial stream: looped transmit data or `serialIn` |
| wordSync | output | 1 | High in the cycle whose closing edge captures `txWord` |

## Verification
The assertions assume that `txWord` and `loopEn` are driven from the same clock domain and are stable around each rising edge. They also assume that `serialIn` is free to change in any cycle. The bench changes every input only at falling edges. It randomizes `serialIn` every cycle and changes `txWord` and `loopEn` both at capture edges and inside words, which exercises the word-boundary rules. A behavioural model built on a bit queue predicts all three outputs in every cycle.

// File: rtl/ser_loopback_pkg.sv
package ser_loopback_pkg;
  typedef struct packed {
    logic load;
    logic shift;
  } serStrobe_t;
endpackage

// File: rtl/ser_loopback_ctrl.sv
module ser_loopback_ctrl
  import ser_loopback_pkg::*;
#(
  parameter int BITS = 10
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       loopEn,
  output serStrobe_t strobe,
  output logic       loopActive
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(BITS - 1);

  logic [CW-1:0] slotCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt    <= '0;
      loopActive <= 1'b0;
    end else begin
      if (slotCnt == LAST) slotCnt <= '0;
      else                 slotCnt <= slotCnt + 1'b1;
      if (strobe.load) loopActive <= loopEn;
    end
  end

  always_comb begin
    strobe.load  = (slotCnt == '0);
    strobe.shift = !strobe.load;
  end
endmodule

// File: rtl/ser_loopback_dp.sv
module ser_loopback_dp
  import ser_loopback_pkg::*;
#(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  serStrobe_t      strobe,
  input  logic            loopActive,
  input  logic [BITS-1:0] txWord,
  input  logic            serialIn,
  output logic            lineOut,
  output logic            rxSerial
);
  localparam logic IDLE_LEVEL = 1'b0;

  logic [BITS-1:0] shiftReg;
  logic            txBit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             shiftReg <= '0;
    else if (strobe.load)  shiftReg <= txWord;
    else if (strobe.shift) shiftReg <= {1'b0, shiftReg[BITS-1:1]};
  end

  assign txBit    = shiftReg[0];
  assign lineOut  = loopActive ? IDLE_LEVEL : txBit;
  assign rxSerial = loopActive ? txBit : serialIn;
endmodule

// File: rtl/ser_loopback_top.sv
module ser_loopback_top
  import ser_loopback_pkg::*;
#(
  parameter int BITS = 10
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [BITS-1:0] txWord,
  input  logic            loopEn,
  input  logic            serialIn,
  output logic            lineOut,
  output logic            rxSerial,
  output logic            wordSync
);
  serStrobe_t strobe;
  logic       loopActive;

  ser_loopback_ctrl #(.BITS(BITS)) u_ctrl (
    .clk(clk), .rstN(rstN), .loopEn(loopEn),
    .strobe(strobe), .loopActive(loopActive)
  );

  ser_loopback_dp #(.BITS(BITS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .loopActive(loopActive),
    .txWord(txWord), .serialIn(serialIn),
    .lineOut(lineOut), .rxSerial(rxSerial)
  );

  assign wordSync = strobe.load;
endmodule

// File: rtl/ser_loopback_chk.sv
module ser_loopback_chk #(
  parameter int BITS = 10
) (
  input logic            clk,
  input logic            rstN,
  input logic [BITS-1:0] txWord,
  input logic            serialIn,
  input logic            lineOut,
  input logic            rxSerial,
  input logic            wordSync,
  input logic            loopActive
);
  logic [31:0] gap;
  logic        seenSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gap      <= '0;
      seenSync <= 1'b0;
    end else if (wordSync) begin
      gap      <= '0;
      seenSync <= 1'b1;
    end else begin
      gap <= gap + 1;
    end
  end

  assert_sync_spacing_R2: assert property (@(posedge clk) disable iff (!rstN)
    (wordSync && seenSync) |-> (gap == 32'(BITS - 1)));

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wordSync) && !loopActive) |-> (lineOut == $past(txWord[0])));

  assert_loop_copy_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && $past(wordSync) && loopActive) |-> (rxSerial == $past(txWord[0])));

  assert_line_quiet_R5: assert property (@(posedge clk) disable iff (!rstN)
    loopActive |-> !lineOut);

  assert_rx_external_R6: assert property (@(posedge clk) disable iff (!rstN)
    !loopActive |-> (rxSerial == serialIn));

  assert_loop_boundary_R7: assert property (@(posedge clk) disable iff (!rstN)
    !wordSync |=> $stable(loopActive));
endmodule

bind ser_loopback_top ser_loopback_chk #(.BITS(BITS)) u_chk (.*);

// File: tb/ser_loopback_top_bench.sv
module ser_loopback_top_bench;
  localparam int BITS = 10;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [BITS-1:0] txWord = '0;
  logic            loopEn = 1'b0;
  logic            serialIn = 1'b0;
  logic            lineOut, rxSerial, wordSync;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  bit mq[$];
  bit curBit = 0;
  bit curLoop = 0;
  bit started = 0;
  bit wordTouched = 0;
  int slot = 0;

  always #2 clk = ~clk;

  ser_loopback_top #(.BITS(BITS)) u_ser_loopback_top (
    .clk(clk), .rstN(rstN), .txWord(txWord), .loopEn(loopEn),
    .serialIn(serialIn), .lineOut(lineOut), .rxSerial(rxSerial),
    .wordSync(wordSync)
  );

  always @(posedge clk) begin
    cycles++;
    if (!rstN) begin
      mq.delete();
      curBit = 0; curLoop = 0; started = 0; slot = 0; wordTouched = 0;
    end else begin
      if (slot == 0) begin
        mq.delete();
        for (int i = 0; i < BITS; i++) mq.push_back(txWord[i]);
        curLoop = loopEn;
        started = 1;
        wordTouched = 0;
      end
      curBit = mq.pop_front();
      slot = (slot + 1) % BITS;
    end
  end

  task automatic check1(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s cycle=%0d actual=%0b expected=%0b", tag, cycles, act, exp);
    end
  endtask

  task automatic checkAll();
    string lt;
    logic expLine, expRx;
    expLine = curLoop ? 1'b0 : curBit;
    expRx   = curLoop ? curBit : serialIn;
    if (!started)                lt = "R1 lineOut";
    else if (loopEn != curLoop)  lt = "R7 lineOut";
    else if (curLoop)            lt = "R5 lineOut";
    else if (wordTouched)        lt = "R8 lineOut";
    else                         lt = "R3 lineOut";
    check1(lt, lineOut, expLine);
    if (!started)           check1("R1 rxSerial", rxSerial, expRx);
    else if (curLoop)       check1("R4 rxSerial", rxSerial, expRx);
    else                    check1("R6 rxSerial", rxSerial, expRx);
    check1("R2 wordSync", wordSync, (slot == 0));
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    logic [BITS-1:0] fixed [4];
    fixed[0] = 10'h3FF; fixed[1] = 10'h000; fixed[2] = 10'h2AA; fixed[3] = 10'h17C;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    txWord = 10'h001;
    // R1: before the first capture edge
    checkAll();
    for (int c = 0; c < 1200; c++) begin
      @(negedge clk);
      checkAll();
      serialIn = 1'($urandom);
      if (slot == 0) begin
        txWord = (c < 60) ? fixed[(c / BITS) % 4] : BITS'($urandom);
        if (c >= 80 && c < 160) loopEn = 1'b1;
        else if (c >= 160 && ($urandom % 3) == 0) loopEn = ~loopEn;
      end else begin
        if (($urandom % 4) == 0) begin
          txWord = BITS'($urandom);
          wordTouched = 1;
        end
        if (c >= 40 && ($urandom % 12) == 0) loopEn = ~loopEn;
      end
    end
    finishRun();
  end

  initial begin
    #200000;
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end
endmodule